// File: doc/BRIEF.md
# MMU and Exception Control Register File

This block is the register file that holds a processor's address-translation and exception state. Software reaches it through a simple request port: one request per cycle carrying a write flag, a window select, an access size, an address and write data. Every request is answered one cycle later with a response strobe, read data and an error flag. Several registers act on what is written to them. Setting the invalidate bit of the MMU control register sends a one-cycle invalidate pulse to an external TLB. Changing the address-space ID in the page-entry-high register sends a one-cycle flush pulse. The event registers and the page-assistance register keep only their low bits. A 16-bit refresh counter steps forward each time it is read.

A second window, chosen by the `win` input, stands in front of the cache and TLB arrays. Address bits 26:24 pick one of eight regions. Only the region number, a strobe and a write flag leave the block. The arrays themselves live elsewhere, so data read through this window is always zero.

Top module: `mmu_exc_regs`

## Requirements
- R1: Each cycle with `req` high is answered in the next cycle by `rsp_valid` high, together with `rdata` and `rsp_err`. A write response carries `rdata` = 0. Size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = reserved.
- R2: The MMU control register sits at offset 0x00. A 32-bit write with bit 2 set raises `tlb_inval` for exactly one cycle, in the cycle after the request. The register stores the other 31 bits unchanged and always reads bit 2 as 0.
- R3: The page-entry-high register sits at offset 0x04 and holds the address-space ID in bits 7:0. A 32-bit write whose bits 7:0 differ from the stored ID raises `tlb_flush` for one cycle, in the cycle after the request. A write that leaves those bits the same raises no pulse.
- R4: The trap code (0x18), exception event (0x1C) and interrupt event (0x20) registers keep bits 10:0 of a write. Bits 31:11 read as 0.
- R5: The page-assistance register at offset 0x0C keeps bits 3:0 of a write. All other bits read as 0.
- R6: The refresh counter at offset 0x24 takes 16-bit accesses only. A read returns the current value and then adds one, wrapping from 0xFFFF to 0. A write loads the value.
- R7: The page-entry-high (0x04), page-entry-low (0x08), table base (0x10) and fault address (0x14) registers hold all 32 bits and read them back.
- R8: The wait-state and memory-control sinks at offsets 0x28 and 0x2C take 32-bit writes with no effect, read as 0 and respond without error.
- R9: In the control window, an access whose size does not match the register is answered with `rsp_err` = 1 and `rdata` = 0. It has no effect: nothing is stored, no pulse is raised and the refresh counter does not advance.
- R10: In the control window, any offset not listed above is answered with `rsp_err` = 1 and `rdata` = 0. This includes any address with a bit above bit 7 set.
- R11: In the array window, a 32-bit access to a TLB region (2, 3, 6 or 7) raises `arr_stb` for one cycle, in the cycle after the request. With it, `arr_region` carries address bits 26:24 and `arr_we` carries the write flag. Cache regions (0, 1, 4, 5) raise no strobe. Every array-window response has `rdata` = 0 and no error.
- R12: In the array window, an access of any size other than 32-bit is answered with `rsp_err` = 1 and raises no strobe.
- R13: Reset clears every register, the refresh counter and every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request valid for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| win | input | 1 | 0 = control register window, 1 = cache/TLB array window |
| size | input | 2 | Access size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| addr | input | 27 | Byte address within the selected window |
| wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after `req` |
| rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access rejected |
| tlb_inval | output | 1 | One-cycle invalidate-all pulse to the TLB |
| tlb_flush | output | 1 | One-cycle flush pulse on a change of address-space ID |
| arr_stb | output | 1 | One-cycle strobe for a TLB array region |
| arr_we | output | 1 | Write flag that goes with `arr_stb` |
| arr_region | output | 3 | Region selected by address bits 26:24 |

## Verification
The hardest effects to observe are the ones that must not happen. These are a rejected access that still advances the refresh counter or raises a pulse, and a page-entry-high write that rewrites the same ID and still flushes. The stimulus brings them out through the normal ports. It first reads the refresh counter at the wrong size, then reads it at the right size and expects the value from before the failed attempt. It also writes page-entry-high twice, with different upper bits but the same low byte, and expects the flush pulse only on the write that changes the ID. A wrong-size write of the invalidate bit is followed by a read-back of the MMU control register to show that its stored value did not change.

// File: rtl/mmu_exc_regs.sv
module mmu_exc_regs #(
  parameter int AW       = 27,
  parameter int REF_W    = 16,
  parameter int EVT_W    = 11,
  parameter int ASSIST_W = 4,
  parameter int ASID_W   = 8,
  parameter int INV_BIT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic          win,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic          rsp_valid,
  output logic [31:0]   rdata,
  output logic          rsp_err,
  output logic          tlb_inval,
  output logic          tlb_flush,
  output logic          arr_stb,
  output logic          arr_we,
  output logic [2:0]    arr_region
);

  localparam logic [7:0] O_MMU = 8'h00, O_PTEH = 8'h04, O_PTEL = 8'h08, O_ASSIST = 8'h0C;
  localparam logic [7:0] O_TBASE = 8'h10, O_FAULT = 8'h14, O_TRAP = 8'h18, O_EXC = 8'h1C;
  localparam logic [7:0] O_INT = 8'h20, O_REF = 8'h24, O_SINK0 = 8'h28, O_SINK1 = 8'h2C;
  localparam logic [1:0] SZ16 = 2'd1, SZ32 = 2'd2;

  logic [31:0]         mmu_q, pteh_q, ptel_q, tbase_q, fault_q;
  logic [ASSIST_W-1:0] assist_q;
  logic [EVT_W-1:0]    trap_q, exc_q, int_q;
  logic [REF_W-1:0]    ref_q;

  logic [7:0]  off;
  logic        known, acc, bad, wr, rd, arr_ok, arr_bad, tlb_hit;
  logic [1:0]  want;
  logic [31:0] rv;

  assign off = addr[7:0];

  always_comb begin
    known = 1'b1;
    want  = SZ32;
    rv    = '0;
    case (off)
      O_MMU:    rv = mmu_q;
      O_PTEH:   rv = pteh_q;
      O_PTEL:   rv = ptel_q;
      O_ASSIST: rv = 32'(assist_q);
      O_TBASE:  rv = tbase_q;
      O_FAULT:  rv = fault_q;
      O_TRAP:   rv = 32'(trap_q);
      O_EXC:    rv = 32'(exc_q);
      O_INT:    rv = 32'(int_q);
      O_REF:    begin want = SZ16; rv = 32'(ref_q); end
      O_SINK0, O_SINK1: rv = '0;
      default:  known = 1'b0;
    endcase
  end

  assign acc     = req & ~win & (addr[AW-1:8] == '0) & known & (size == want);
  assign bad     = req & ~win & ~acc;
  assign wr      = acc & we;
  assign rd      = acc & ~we;
  assign arr_ok  = req & win & (size == SZ32);
  assign arr_bad = req & win & (size != SZ32);
  assign tlb_hit = arr_ok & addr[25];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rdata      <= '0;
      rsp_err    <= 1'b0;
      tlb_inval  <= 1'b0;
      tlb_flush  <= 1'b0;
      arr_stb    <= 1'b0;
      arr_we     <= 1'b0;
      arr_region <= '0;
      mmu_q      <= '0;
      pteh_q     <= '0;
      ptel_q     <= '0;
      tbase_q    <= '0;
      fault_q    <= '0;
      assist_q   <= '0;
      trap_q     <= '0;
      exc_q      <= '0;
      int_q      <= '0;
      ref_q      <= '0;
    end else begin
      rsp_valid <= req;
      rsp_err   <= bad | arr_bad;
      rdata     <= rd ? rv : '0;
      tlb_inval <= wr & (off == O_MMU) & wdata[INV_BIT];
      tlb_flush <= wr & (off == O_PTEH) & (wdata[ASID_W-1:0] != pteh_q[ASID_W-1:0]);
      arr_stb   <= tlb_hit;
      arr_we    <= tlb_hit & we;
      if (tlb_hit) arr_region <= addr[26:24];
      if (wr) begin
        case (off)
          O_MMU:    mmu_q    <= wdata & ~(32'd1 << INV_BIT);
          O_PTEH:   pteh_q   <= wdata;
          O_PTEL:   ptel_q   <= wdata;
          O_ASSIST: assist_q <= wdata[ASSIST_W-1:0];
          O_TBASE:  tbase_q  <= wdata;
          O_FAULT:  fault_q  <= wdata;
          O_TRAP:   trap_q   <= wdata[EVT_W-1:0];
          O_EXC:    exc_q    <= wdata[EVT_W-1:0];
          O_INT:    int_q    <= wdata[EVT_W-1:0];
          O_REF:    ref_q    <= wdata[REF_W-1:0];
          default:  ;
        endcase
      end
      if (rd && off == O_REF) ref_q <= ref_q + {{(REF_W-1){1'b0}}, 1'b1};
    end
  end

  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);

  // R2
  inval_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inval |-> $past(req && we && !win && size == SZ32 && addr == AW'(O_MMU) && wdata[INV_BIT]));

  // R2
  inval_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req && !we && !win && addr == AW'(O_MMU))) |-> !rdata[INV_BIT]);

  // R3
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(req && we && !win && size == SZ32 && addr == AW'(O_PTEH)));

  // R4
  evt_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req && !we && !win &&
      (addr == AW'(O_TRAP) || addr == AW'(O_EXC) || addr == AW'(O_INT))))
    |-> (rdata[31:EVT_W] == '0));

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rdata == '0));

  // R12
  arr_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_stb |-> $past(req && win && size == SZ32));

endmodule

// File: tb/sim_mmu_exc_regs.sv
module sim_mmu_exc_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, win = 1'b0;
  logic [1:0] size = 2'd0;
  logic [26:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rsp_valid, rsp_err, tlb_inval, tlb_flush, arr_stb, arr_we;
  logic [31:0] rdata;
  logic [2:0] arr_region;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mmu_exc_regs u0 (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .win(win), .size(size),
    .addr(addr), .wdata(wdata), .rsp_valid(rsp_valid), .rdata(rdata), .rsp_err(rsp_err),
    .tlb_inval(tlb_inval), .tlb_flush(tlb_flush), .arr_stb(arr_stb), .arr_we(arr_we),
    .arr_region(arr_region));

  typedef struct packed {
    logic [3:0] rq; logic w; logic wn; logic [1:0] sz; logic [26:0] ad;
    logic [31:0] wd; logic [31:0] rd; logic er; logic inv; logic fl; logic stb; logic awe; logic [2:0] rg;
  } vec_t;

  function automatic vec_t mk(int rq, int w, int wn, int sz, logic [26:0] ad, logic [31:0] wd,
                              logic [31:0] rd, int er, int inv, int fl, int stb, int awe, int rg);
    vec_t v;
    v.rq = 4'(rq); v.w = 1'(w); v.wn = 1'(wn); v.sz = 2'(sz); v.ad = ad; v.wd = wd; v.rd = rd;
    v.er = 1'(er); v.inv = 1'(inv); v.fl = 1'(fl); v.stb = 1'(stb); v.awe = 1'(awe); v.rg = 3'(rg);
    return v;
  endfunction

  localparam int NV = 45;
  localparam vec_t V [NV] = '{
    mk(13,0,0,2,27'h00,32'h0,32'h0,0,0,0,0,0,0),              // R13 reset value
    mk(2,1,0,2,27'h00,32'h105,32'h0,0,1,0,0,0,0),             // R2 invalidate pulse
    mk(2,0,0,2,27'h00,32'h0,32'h101,0,0,0,0,0,0),             // R2 bit reads 0
    mk(3,1,0,2,27'h04,32'h12345600,32'h0,0,0,0,0,0,0),        // R3 same id
    mk(3,1,0,2,27'h04,32'h12345677,32'h0,0,0,1,0,0,0),        // R3 id change
    mk(3,1,0,2,27'h04,32'hABCDEF77,32'h0,0,0,0,0,0,0),        // R3 upper change only
    mk(7,0,0,2,27'h04,32'h0,32'hABCDEF77,0,0,0,0,0,0),        // R7
    mk(4,1,0,2,27'h18,32'hFFFFFFFF,32'h0,0,0,0,0,0,0),        // R4
    mk(4,0,0,2,27'h18,32'h0,32'h7FF,0,0,0,0,0,0),             // R4
    mk(4,1,0,2,27'h1C,32'h12345678,32'h0,0,0,0,0,0,0),        // R4
    mk(4,0,0,2,27'h1C,32'h0,32'h678,0,0,0,0,0,0),             // R4
    mk(4,1,0,2,27'h20,32'hFFFFF800,32'h0,0,0,0,0,0,0),        // R4
    mk(4,0,0,2,27'h20,32'h0,32'h0,0,0,0,0,0,0),               // R4
    mk(5,1,0,2,27'h0C,32'hFFFFFFFA,32'h0,0,0,0,0,0,0),        // R5
    mk(5,0,0,2,27'h0C,32'h0,32'hA,0,0,0,0,0,0),               // R5
    mk(7,1,0,2,27'h10,32'hDEADBEEF,32'h0,0,0,0,0,0,0),        // R7
    mk(7,0,0,2,27'h10,32'h0,32'hDEADBEEF,0,0,0,0,0,0),        // R7
    mk(7,1,0,2,27'h08,32'h0F0F0F0F,32'h0,0,0,0,0,0,0),        // R7
    mk(7,0,0,2,27'h08,32'h0,32'h0F0F0F0F,0,0,0,0,0,0),        // R7
    mk(7,1,0,2,27'h14,32'h13579BDF,32'h0,0,0,0,0,0,0),        // R7
    mk(7,0,0,2,27'h14,32'h0,32'h13579BDF,0,0,0,0,0,0),        // R7
    mk(8,1,0,2,27'h2C,32'hFFFFFFFF,32'h0,0,0,0,0,0,0),        // R8
    mk(8,0,0,2,27'h2C,32'h0,32'h0,0,0,0,0,0,0),               // R8
    mk(8,0,0,2,27'h28,32'h0,32'h0,0,0,0,0,0,0),               // R8
    mk(6,0,0,1,27'h24,32'h0,32'h0,0,0,0,0,0,0),               // R6
    mk(6,0,0,1,27'h24,32'h0,32'h1,0,0,0,0,0,0),               // R6
    mk(6,1,0,1,27'h24,32'h0000FFFF,32'h0,0,0,0,0,0,0),        // R6
    mk(6,0,0,1,27'h24,32'h0,32'hFFFF,0,0,0,0,0,0),            // R6
    mk(6,0,0,1,27'h24,32'h0,32'h0,0,0,0,0,0,0),               // R6 wrap
    mk(9,0,0,1,27'h00,32'h0,32'h0,1,0,0,0,0,0),               // R9
    mk(9,1,0,0,27'h00,32'h4,32'h0,1,0,0,0,0,0),               // R9 no pulse
    mk(9,0,0,2,27'h00,32'h0,32'h101,0,0,0,0,0,0),             // R9 unchanged
    mk(9,0,0,2,27'h24,32'h0,32'h0,1,0,0,0,0,0),               // R9 no advance
    mk(9,0,0,1,27'h24,32'h0,32'h1,0,0,0,0,0,0),               // R9
    mk(10,0,0,2,27'h80,32'h0,32'h0,1,0,0,0,0,0),              // R10
    mk(10,1,0,2,27'h30,32'h1,32'h0,1,0,0,0,0,0),              // R10
    mk(10,0,0,2,27'h100,32'h0,32'h0,1,0,0,0,0,0),             // R10
    mk(11,0,1,2,27'h6000010,32'h0,32'h0,0,0,0,1,0,6),         // R11 utlb
    mk(11,1,1,2,27'h3000000,32'h5,32'h0,0,0,0,1,1,3),         // R11 itlb data
    mk(11,0,1,2,27'h0000040,32'h0,32'h0,0,0,0,0,0,0),         // R11 cache
    mk(11,1,1,2,27'h5000000,32'h7,32'h0,0,0,0,0,0,0),         // R11 cache
    mk(12,0,1,1,27'h2000000,32'h0,32'h0,1,0,0,0,0,0),         // R12
    mk(12,1,1,3,27'h7000000,32'h0,32'h0,1,0,0,0,0,0),         // R12
    mk(2,1,0,2,27'h00,32'hFFFFFFFF,32'h0,0,1,0,0,0,0),        // R2
    mk(2,0,0,2,27'h00,32'h0,32'hFFFFFFFB,0,0,0,0,0,0)         // R2
  };

  task automatic chk(bit ok, int rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic op(vec_t v);
    @(negedge clk);
    req = 1'b1; we = v.w; win = v.wn; size = v.sz; addr = v.ad; wdata = v.wd;
    @(negedge clk);
    req = 1'b0; we = 1'b0; win = 1'b0; size = 2'd0; addr = '0; wdata = '0;
    chk(rsp_valid === 1'b1, v.rq, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rdata === v.rd, v.rq, "rdata", rdata, v.rd);
    chk(rsp_err === v.er, v.rq, "rsp_err", 32'(rsp_err), 32'(v.er));
    chk(tlb_inval === v.inv, v.rq, "tlb_inval", 32'(tlb_inval), 32'(v.inv));
    chk(tlb_flush === v.fl, v.rq, "tlb_flush", 32'(tlb_flush), 32'(v.fl));
    chk(arr_stb === v.stb, v.rq, "arr_stb", 32'(arr_stb), 32'(v.stb));
    chk(arr_we === v.awe, v.rq, "arr_we", 32'(arr_we), 32'(v.awe));
    if (v.stb) chk(arr_region === v.rg, v.rq, "arr_region", 32'(arr_region), 32'(v.rg));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 outputs idle after reset; R1 no response without request
    chk(rsp_valid === 1'b0 && rsp_err === 1'b0, 13, "rsp idle", 32'({rsp_valid, rsp_err}), 32'd0);
    chk(tlb_inval === 1'b0 && tlb_flush === 1'b0 && arr_stb === 1'b0, 13, "pulses idle",
        32'({tlb_inval, tlb_flush, arr_stb}), 32'd0);
    for (int i = 0; i < NV; i++) op(V[i]);
    // R1 idle cycle after a request gives no response
    @(negedge clk);
    chk(rsp_valid === 1'b0, 1, "rsp_valid idle", 32'(rsp_valid), 32'd0);
    // R13 reset mid-run clears stored state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    op(mk(13,0,0,2,27'h04,32'h0,32'h0,0,0,0,0,0,0));
    op(mk(13,0,0,1,27'h24,32'h0,32'h0,0,0,0,0,0,0));
    op(mk(13,0,0,2,27'h00,32'h0,32'h0,0,0,0,0,0,0));
    // R3 first write after reset with nonzero id flushes
    op(mk(3,1,0,2,27'h04,32'h00000001,32'h0,0,0,1,0,0,0));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule